// File: doc/BRIEF.md
# Toggle Bit Polling Controller

This block runs on the host side of a flash memory. It decides whether a program or erase operation inside the device has finished, and whether it succeeded. After a `start` pulse it latches the bank address from `poll_addr`. It then issues status reads to that address in pairs over a simple request/acknowledge bus and compares the toggle bit (bit 6) of the two reads in each pair. If the bit holds still, the operation is over and the result is pass.

If the bit moved and the timeout flag (bit 5) is low, the block reads another pair. If the bit moved and the timeout flag is high, the block reads one more pair to cover the race where toggling stops just as the flag rises. If toggling has stopped in that pair, the result is pass. If it has not, the block writes the reset command 0xF0 to the bank address, which returns the device to array reads, and reports fail. A parameter sets the maximum number of plain read pairs. When that limit is used up, the block also writes the reset command and reports fail.

While a poll is in progress, `bank_hold` is high, so the bus arbiter can keep reads to other banks out of the status sequence. The `abandon` input drops the poll so the host can do other work. A later `start` begins again from the first read of a fresh pair.

Top module: `tbp_ctrl`

## Requirements
- R1: After reset, `bus_req`, `bank_hold`, `done`, `pass` and `fail` are all low.
- R2: On `start` in idle, the block issues read requests (`bus_we` low) to the address sampled on `poll_addr`. Every request of the poll uses that address, and `bank_hold` is high whenever a request is pending and low once `done` has been given.
- R3: If the bit-6 values of the first two reads are equal, the poll ends after exactly two reads with pass and no write.
- R4: If the bit-6 values of a pair differ and bit 5 of the second read is low, a further pair of reads follows.
- R5: If a pair differs and bit 5 of its second read is high, exactly two more reads follow. If their bit-6 values are equal, the result is pass with no write.
- R6: If that recheck pair still differs, the block issues one write of 0xF0 to the bank address and then reports fail.
- R7: With MAX_PAIRS set, if MAX_PAIRS consecutive plain pairs all differ with bit 5 low, the block writes 0xF0 after the last of them and reports fail, having made 2*MAX_PAIRS reads.
- R8: `abandon` during a read that has not been acknowledged returns the block to idle with `bus_req` and `bank_hold` low and no `done`. The next `start` begins a fresh pair and does not use values read before the abandon.
- R9: `done` is a one-cycle pulse, given together with exactly one of `pass` or `fail`. The result flags stay unchanged until the next accepted `start`.
- R10: A request stays asserted with a stable address and direction until `bus_ack`, whatever the acknowledge latency.
- R11: A `start` pulse while a poll is running is ignored, and the poll keeps its original address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a poll (pulse) |
| abandon | input | 1 | Drop the running poll while a read waits |
| poll_addr | input | ADDR_W | Bank address to poll, sampled on start |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_we | output | 1 | 1 = write (reset command), 0 = status read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Write data (0xF0 on writes) |
| bus_ack | input | 1 | Transfer completes on a cycle with bus_req and bus_ack high |
| bus_rdata | input | DATA_W | Status byte, valid with bus_ack |
| bank_hold | output | 1 | Tells the arbiter to keep other-bank reads off the bus |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation succeeded |
| fail | output | 1 | Operation failed; reset command already written |

## Verification
The bench targets the recheck race. A design that treats a high timeout flag as failure at once reports fail where the recheck pair would have shown pass. A design that skips the reset write reports fail with no 0xF0 on the bus. It also checks the pair limit, counting reads exactly so that an off-by-one limit shows up as 6 or 10 reads instead of 8. For abandon, it returns a different first value before the abandon, so a design that keeps a stale first sample sees a false toggle. It also uses acknowledge latencies and mid-poll start pulses that would make a design drop or retarget a waiting request.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_CHK_A,
    ST_CHK_B,
    ST_WR_RST
  } tbp_state_e;
endpackage

// File: rtl/tbp_rst_sync.sv
module tbp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/tbp_bit_pair.sv
// Holds the toggle bit of the first read of a pair and flags a change on the second.
module tbp_bit_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic bit_in,
  output logic changed
);
  logic first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      first_q <= 1'b0;
    else if (cap_en) first_q <= bit_in;
  end

  assign changed = bit_in ^ first_q;
endmodule

// File: rtl/tbp_pair_cnt.sv
// Counts plain read pairs that still toggled; at_limit marks the last one allowed.
module tbp_pair_cnt #(
  parameter int MAX_PAIRS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CNT_W = $clog2(MAX_PAIRS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_PAIRS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                  cnt_d = '0;
    else if (inc && !at_limit) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign at_limit = (cnt_q == LAST);
endmodule

// File: rtl/tbp_fsm.sv
module tbp_fsm
  import tbp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abandon,
  input  logic bus_ack,
  input  logic tog_changed,
  input  logic err_now,
  input  logic at_limit,
  output logic bus_req,
  output logic bus_we,
  output logic bank_hold,
  output logic addr_ld,
  output logic cap_en,
  output logic cnt_clr,
  output logic cnt_inc,
  output logic done,
  output logic pass,
  output logic fail
);
  tbp_state_e st_q, st_d;
  logic fin_pass, fin_fail;
  logic done_q, pass_q, fail_q;

  always_comb begin
    st_d     = st_q;
    addr_ld  = 1'b0;
    cap_en   = 1'b0;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    fin_pass = 1'b0;
    fin_fail = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d    = ST_RD_A;
          addr_ld = 1'b1;
          cnt_clr = 1'b1;
        end
      end
      ST_RD_A, ST_CHK_A: begin
        if (bus_ack) begin
          cap_en = 1'b1;
          st_d   = (st_q == ST_RD_A) ? ST_RD_B : ST_CHK_B;
        end else if (abandon) begin
          st_d = ST_IDLE;
        end
      end
      ST_RD_B: begin
        if (bus_ack) begin
          if (!tog_changed) begin
            fin_pass = 1'b1;
            st_d     = ST_IDLE;
          end else if (err_now) begin
            st_d = ST_CHK_A;
          end else if (at_limit) begin
            st_d = ST_WR_RST;
          end else begin
            cnt_inc = 1'b1;
            st_d    = ST_RD_A;
          end
        end else if (abandon) begin
          st_d = ST_IDLE;
        end
      end
      ST_CHK_B: begin
        if (bus_ack) begin
          if (!tog_changed) begin
            fin_pass = 1'b1;
            st_d     = ST_IDLE;
          end else begin
            st_d = ST_WR_RST;
          end
        end else if (abandon) begin
          st_d = ST_IDLE;
        end
      end
      ST_WR_RST: begin
        if (bus_ack) begin
          fin_fail = 1'b1;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin_pass | fin_fail;
      if (addr_ld) begin
        pass_q <= 1'b0;
        fail_q <= 1'b0;
      end else if (fin_pass) begin
        pass_q <= 1'b1;
      end else if (fin_fail) begin
        fail_q <= 1'b1;
      end
    end
  end

  assign bus_req   = (st_q != ST_IDLE);
  assign bus_we    = (st_q == ST_WR_RST);
  assign bank_hold = (st_q != ST_IDLE);
  assign done      = done_q;
  assign pass      = pass_q;
  assign fail      = fail_q;
endmodule

// File: rtl/tbp_ctrl.sv
module tbp_ctrl #(
  parameter int              ADDR_W    = 24,
  parameter int              DATA_W    = 8,
  parameter int              TOG_BIT   = 6,
  parameter int              ERR_BIT   = 5,
  parameter int              MAX_PAIRS = 4096,
  parameter logic [DATA_W-1:0] RST_CMD = DATA_W'(8'hF0)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abandon,
  input  logic [ADDR_W-1:0] poll_addr,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bank_hold,
  output logic              done,
  output logic              pass,
  output logic              fail
);
  logic              rst_sync_n;
  logic              addr_ld, cap_en, cnt_clr, cnt_inc;
  logic              tog_changed, at_limit;
  logic [ADDR_W-1:0] addr_q;
  logic              rdata_unused;

  assign rdata_unused = ^bus_rdata;

  tbp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  addr_q <= '0;
    else if (addr_ld) addr_q <= poll_addr;
  end

  tbp_bit_pair u_pair (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cap_en  (cap_en),
    .bit_in  (bus_rdata[TOG_BIT]),
    .changed (tog_changed)
  );

  tbp_pair_cnt #(.MAX_PAIRS(MAX_PAIRS)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (cnt_clr),
    .inc      (cnt_inc),
    .at_limit (at_limit)
  );

  tbp_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (start),
    .abandon     (abandon),
    .bus_ack     (bus_ack),
    .tog_changed (tog_changed),
    .err_now     (bus_rdata[ERR_BIT]),
    .at_limit    (at_limit),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bank_hold   (bank_hold),
    .addr_ld     (addr_ld),
    .cap_en      (cap_en),
    .cnt_clr     (cnt_clr),
    .cnt_inc     (cnt_inc),
    .done        (done),
    .pass        (pass),
    .fail        (fail)
  );

  assign bus_addr  = addr_q;
  assign bus_wdata = bus_we ? RST_CMD : '0;
endmodule

// File: rtl/tbp_ctrl_chk.sv
module tbp_ctrl_chk #(
  parameter int              ADDR_W  = 24,
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] RST_CMD = DATA_W'(8'hF0)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              abandon,
  input logic [ADDR_W-1:0] poll_addr,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bank_hold,
  input logic              done,
  input logic              pass,
  input logic              fail
);
  logic rdata_unused;
  assign rdata_unused = ^bus_rdata;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && (!abandon || bus_we) |=> bus_req && $stable(bus_addr) && $stable(bus_we)); // R10
  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ fail)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> bus_wdata == RST_CMD); // R6
  AST_FAIL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done && fail |-> $past(bus_req && bus_we && bus_ack)); // R6
  AST_PASS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done && pass |-> $past(bus_req && !bus_we && bus_ack)); // R3
  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start && !bank_hold |=> bus_req && !bus_we && bus_addr == $past(poll_addr)); // R2
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bank_hold && !bus_req); // R2
  AST_ABANDON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we && !bus_ack && abandon |=> !bus_req && !done); // R8
endmodule

bind tbp_ctrl tbp_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_CMD(RST_CMD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start     (start),
  .abandon   (abandon),
  .poll_addr (poll_addr),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_ack   (bus_ack),
  .bus_rdata (bus_rdata),
  .bank_hold (bank_hold),
  .done      (done),
  .pass      (pass),
  .fail      (fail)
);

// File: tb/sim_tbp_ctrl.sv
module sim_tbp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 16;
  localparam int DW   = 8;
  localparam int MAXP = 4;

  logic          clk, rst_n, start, abandon;
  logic [AW-1:0] poll_addr;
  logic          bus_req, bus_we, bus_ack;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          bank_hold, done, pass, fail;

  tbp_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MAX_PAIRS(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .abandon(abandon), .poll_addr(poll_addr),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bank_hold(bank_hold),
    .done(done), .pass(pass), .fail(fail)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Device model state
  logic [7:0]    script [0:15];
  int            sidx, lat, wcnt, n_rd, n_wr, addr_err, hold_err;
  logic [7:0]    last_wd;
  logic [AW-1:0] exp_addr;
  int            n_cmp, n_bad, cyc;
  bit            finished;

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack   = 1'b0;
      bus_rdata = '0;
      wcnt      = 0;
    end else if (bus_ack) begin
      bus_ack = 1'b0;
      wcnt    = 0;
    end else if (bus_req) begin
      if (!bank_hold) hold_err++;
      if (wcnt >= lat) begin
        bus_ack = 1'b1;
        if (bus_addr != exp_addr) addr_err++;
        if (bus_we) begin
          n_wr++;
          last_wd = bus_wdata;
        end else begin
          n_rd++;
          bus_rdata = script[sidx % 16];
          sidx++;
        end
      end else begin
        wcnt++;
      end
    end else begin
      wcnt = 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic prep(input int latency);
    sidx = 0; n_rd = 0; n_wr = 0; addr_err = 0; hold_err = 0; last_wd = 8'h00;
    lat = latency;
    for (int i = 0; i < 16; i++) script[i] = 8'h00;
  endtask

  task automatic kick(input logic [AW-1:0] a);
    @(negedge clk);
    poll_addr = a;
    exp_addr  = a;
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
  endtask

  task automatic wait_done(input string req);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(req, "done seen", int'(seen), 1);
  endtask

  task automatic check_end(input string req, input int e_pass, input int e_rd, input int e_wr);
    chk(req, "pass", int'(pass), e_pass);
    chk(req, "fail", int'(fail), 1 - e_pass);
    chk(req, "reads", n_rd, e_rd);
    chk(req, "writes", n_wr, e_wr);
    if (e_wr > 0) chk(req, "write data", int'(last_wd), 8'hF0);
    chk("R2", "address errors", addr_err, 0);
    chk("R2", "hold errors", hold_err, 0);
    @(negedge clk);
    chk("R9", "done one cycle", int'(done), 0);
    chk("R9", "pass held", int'(pass), e_pass);
    chk("R2", "hold released", int'(bank_hold), 0);
  endtask

  task automatic t_reset;
    chk("R1", "bus_req", int'(bus_req), 0);
    chk("R1", "bank_hold", int'(bank_hold), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "pass", int'(pass), 0);
    chk("R1", "fail", int'(fail), 0);
  endtask

  task automatic t_stopped_first;
    prep(0);
    script[0] = 8'h40; script[1] = 8'h40;
    kick(16'h1200);
    wait_done("R3");
    check_end("R3", 1, 2, 0);
  endtask

  task automatic t_two_pairs;
    prep(2);
    script[0] = 8'h00; script[1] = 8'h40; script[2] = 8'h40; script[3] = 8'h40;
    kick(16'h2301);
    wait_done("R4");
    check_end("R4", 1, 4, 0);
    chk("R10", "latency 2 reads", n_rd, 4);
  endtask

  task automatic t_recheck_pass;
    prep(1);
    script[0] = 8'h00; script[1] = 8'h60; script[2] = 8'h40; script[3] = 8'h40;
    kick(16'h3402);
    wait_done("R5");
    check_end("R5", 1, 4, 0);
  endtask

  task automatic t_recheck_fail;
    prep(0);
    script[0] = 8'h00; script[1] = 8'h60; script[2] = 8'h20; script[3] = 8'h60;
    kick(16'h4503);
    wait_done("R6");
    check_end("R6", 0, 4, 1);
  endtask

  task automatic t_limit;
    prep(0);
    for (int i = 0; i < 16; i++) script[i] = (i % 2 == 0) ? 8'h00 : 8'h40;
    kick(16'h5604);
    wait_done("R7");
    check_end("R7", 0, 2 * MAXP, 1);
  endtask

  task automatic t_abandon;
    int dcnt;
    prep(3);
    script[0] = 8'h00; script[1] = 8'h40; script[2] = 8'h40;
    kick(16'h6705);
    for (int i = 0; i < 50 && n_rd < 1; i++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    abandon = 1'b1;
    @(negedge clk);
    abandon = 1'b0;
    chk("R8", "bus_req after abandon", int'(bus_req), 0);
    chk("R8", "hold after abandon", int'(bank_hold), 0);
    dcnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done) dcnt++;
    end
    chk("R8", "no done after abandon", dcnt, 0);
    chk("R8", "reads before restart", n_rd, 1);
    kick(16'h6705);
    wait_done("R8");
    check_end("R8", 1, 3, 0);
  endtask

  task automatic t_start_busy;
    prep(2);
    script[0] = 8'h00; script[1] = 8'h40; script[2] = 8'h40; script[3] = 8'h40;
    kick(16'h7806);
    for (int i = 0; i < 50 && n_rd < 1; i++) @(negedge clk);
    poll_addr = 16'h0BAD;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R11");
    check_end("R11", 1, 4, 0);
    chk("R11", "address errors", addr_err, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; cyc = 0; finished = 1'b0;
    rst_n = 1'b0; start = 1'b0; abandon = 1'b0; poll_addr = '0; exp_addr = '0;
    prep(0);
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_stopped_first;
    t_two_pairs;
    t_recheck_pass;
    t_recheck_fail;
    t_limit;
    t_abandon;
    t_start_busy;
    t_stopped_first;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule